// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A requester presents an address, the current process identifier and the base of the first-level table. The block first remaps low addresses into a per-process window. It then fetches the first-level descriptor and, if that descriptor points to a second-level table, fetches one more descriptor. It reports the physical address, the two access-permission bits and the four-bit domain that apply, or a translation fault.

The mapping can be coarse or fine. A 1 MB section resolves after one memory read. Coarse and fine second-level tables resolve after two reads into 64 KB, 4 KB or 1 KB pages. On 64 KB and 4 KB pages each quarter of the page carries its own permission field. Only one walk runs at a time, and the memory port issues a single-cycle read strobe and waits for a data-valid pulse, with any latency.

Top module: `page_walker`

## Requirements
- R1: After reset, rsp_valid and mem_req are low and req_ready is high.
- R2: When req_vaddr[31:25] is zero, the walk uses req_vaddr + req_pid × 0x0200_0000. Otherwise it uses req_vaddr unchanged. All address fields below refer to this modified address (MVA).
- R3: The first read is at byte address {ttb_base[31:14], MVA[31:20], 2'b00}. The descriptor kind is in bits [1:0]: 00 fault, 01 coarse table, 10 section, 11 fine table. The domain is in bits [8:5].
- R4: A section descriptor ends the walk after exactly one read. The result is paddr = {desc[31:20], MVA[19:0]}, with ap = desc[11:10].
- R5: A coarse descriptor causes a second read at {desc[31:10], MVA[19:12], 2'b00}.
- R6: A fine descriptor causes a second read at {desc[31:12], MVA[19:10], 2'b00}.
- R7: Second-level kinds are in bits [1:0]: 00 fault, 01 64 KB, 10 4 KB, 11 1 KB. A 64 KB page gives paddr = {desc[31:16], MVA[15:0]}, with ap taken from desc[2q+5:2q+4] where q = MVA[15:14].
- R8: A 4 KB page gives paddr = {desc[31:12], MVA[11:0]}, with ap taken from desc[2q+5:2q+4] where q = MVA[11:10].
- R9: A 1 KB page gives paddr = {desc[31:10], MVA[9:0]}, with ap = desc[5:4].
- R10: A first-level fault descriptor ends the walk after one read with rsp_fault high and paddr, ap and domain all zero.
- R11: A second-level fault descriptor ends the walk with rsp_fault high, paddr and ap zero, and the domain of the first-level descriptor.
- R12: req_ready is low from acceptance until the result has been presented. Requests made in that time are ignored. rsp_valid lasts one cycle, and at most one read is outstanding.
- R13: Every successful result carries the domain field of the first-level descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; request taken when both high |
| req_vaddr | input | 32 | Virtual address |
| req_pid | input | 7 | Process identifier |
| ttb_base | input | 32 | First-level table base (bits [31:14] used) |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Byte address of the descriptor |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_ap | output | 2 | Access-permission bits |
| rsp_domain | output | 4 | Domain number |
| rsp_fault | output | 1 | Translation fault |

## Verification
The assertions watch, on every cycle, the protocol rules of the walk. The result is a single-cycle pulse that never overlaps an idle state. No second read is issued while one is outstanding. The first read lands on the captured table base. A section or fault ends after one read, while a table pointer is followed by a second read. Faulting results carry zero address and permissions. The bit-level decoding cannot be checked that way and is shown only by the directed scenarios: address remapping, table indexing, page-size address assembly, quarter selection of permissions, and the carrying of the domain. Each scenario programs descriptors into a modelled memory and compares the outputs against values the bench derives itself.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W    = 32;
  localparam int PID_W   = 7;
  localparam int MOD_LSB = VA_W - PID_W;
  localparam int DOM_W   = 4;
  localparam int AP_W    = 2;
  localparam int TTB_W   = 18;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00,
    L2_LARGE = 2'b01,
    L2_SMALL = 2'b10,
    L2_TINY  = 2'b11
  } l2_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic             fault;
    logic [VA_W-1:0]  paddr;
    logic [AP_W-1:0]  ap;
    logic [DOM_W-1:0] domain;
  } xlate_t;

  function automatic logic [VA_W-1:0] remap_va(input logic [VA_W-1:0] va,
                                               input logic [PID_W-1:0] pid);
    if (va[VA_W-1:MOD_LSB] == '0) return {pid, va[MOD_LSB-1:0]};
    return va;
  endfunction

  function automatic logic [VA_W-1:0] first_fetch(input logic [TTB_W-1:0] ttb,
                                                  input logic [VA_W-1:0] mva);
    return {ttb, mva[31:20], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] second_fetch(input logic [VA_W-1:0] l1e,
                                                   input logic [VA_W-1:0] mva);
    if (l1_kind_e'(l1e[1:0]) == L1_COARSE) return {l1e[31:10], mva[19:12], 2'b00};
    return {l1e[31:12], mva[19:10], 2'b00};
  endfunction

  function automatic logic [AP_W-1:0] quarter_ap(input logic [7:0] aps,
                                                 input logic [1:0] q);
    case (q)
      2'd0:    return aps[1:0];
      2'd1:    return aps[3:2];
      2'd2:    return aps[5:4];
      default: return aps[7:6];
    endcase
  endfunction

  function automatic logic [DOM_W-1:0] desc_domain(input logic [VA_W-1:0] l1e);
    return l1e[8:5];
  endfunction
endpackage

// File: rtl/pw_mva.sv
module pw_mva
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [PID_W-1:0] pid,
  output logic [VA_W-1:0]  mva,
  output logic             remapped
);
  assign remapped = (va[VA_W-1:MOD_LSB] == '0);
  assign mva      = remap_va(va, pid);
endmodule

// File: rtl/pw_l1_decode.sv
module pw_l1_decode
  import pw_pkg::*;
(
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] mva,
  output logic            is_table,
  output xlate_t          result
);
  l1_kind_e kind;
  logic     unused_desc;

  assign kind        = l1_kind_e'(desc[1:0]);
  assign is_table    = (kind == L1_COARSE) || (kind == L1_FINE);
  assign unused_desc = ^{desc[19:12], desc[9], desc[4:2], mva[31:20]};

  always_comb begin
    result = '0;
    case (kind)
      L1_SECTION: begin
        result.paddr  = {desc[31:20], mva[19:0]};
        result.ap     = desc[11:10];
        result.domain = desc_domain(desc);
      end
      L1_FAULT: result.fault = 1'b1;
      default:  result.domain = desc_domain(desc);
    endcase
  end
endmodule

// File: rtl/pw_l2_decode.sv
module pw_l2_decode
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  desc,
  input  logic [VA_W-1:0]  mva,
  input  logic [DOM_W-1:0] domain,
  output xlate_t           result
);
  l2_kind_e kind;
  logic     unused_bits;

  assign kind        = l2_kind_e'(desc[1:0]);
  assign unused_bits = ^{desc[3:2], mva[31:16]};

  always_comb begin
    result        = '0;
    result.domain = domain;
    case (kind)
      L2_LARGE: begin
        result.paddr = {desc[31:16], mva[15:0]};
        result.ap    = quarter_ap(desc[11:4], mva[15:14]);
      end
      L2_SMALL: begin
        result.paddr = {desc[31:12], mva[11:0]};
        result.ap    = quarter_ap(desc[11:4], mva[11:10]);
      end
      L2_TINY: begin
        result.paddr = {desc[31:10], mva[9:0]};
        result.ap    = desc[5:4];
      end
      default: result.fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/pw_walk_ctrl.sv
module pw_walk_ctrl
  import pw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_valid,
  input  logic l1_is_table,
  output logic req_ready,
  output logic mem_req,
  output logic sel_l2,
  output logic accept_ev,
  output logic l1_take_ev,
  output logic l2_take_ev,
  output logic done
);
  walk_st_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (req_valid) st_nx = ST_RD1;
      ST_RD1:  st_nx = ST_WT1;
      ST_WT1:  if (mem_valid) st_nx = l1_is_table ? ST_RD2 : ST_DONE;
      ST_RD2:  st_nx = ST_WT2;
      ST_WT2:  if (mem_valid) st_nx = ST_DONE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign req_ready  = (st == ST_IDLE);
  assign accept_ev  = req_ready && req_valid;
  assign mem_req    = (st == ST_RD1) || (st == ST_RD2);
  assign sel_l2     = (st == ST_RD2);
  assign l1_take_ev = (st == ST_WT1) && mem_valid;
  assign l2_take_ev = (st == ST_WT2) && mem_valid;
  assign done       = (st == ST_DONE);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [6:0]       req_pid,
  input  logic [31:0]      ttb_base,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_valid,
  input  logic [31:0]      mem_rdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_paddr,
  output logic [1:0]       rsp_ap,
  output logic [3:0]       rsp_domain,
  output logic             rsp_fault
);
  logic [VA_W-1:0]  mva_w, mva_q, l1_q;
  logic [TTB_W-1:0] ttb_q;
  logic             remap_ev, accept_ev, l1_take_ev, l2_take_ev, l1_is_table, sel_l2;
  xlate_t           l1_res, l2_res, res_q;
  logic             unused_ttb;

  assign unused_ttb = ^{ttb_base[31-TTB_W:0], remap_ev};

  pw_mva u_mva (.va(req_vaddr), .pid(req_pid), .mva(mva_w), .remapped(remap_ev));

  pw_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_valid(mem_valid),
    .l1_is_table(l1_is_table), .req_ready(req_ready), .mem_req(mem_req),
    .sel_l2(sel_l2), .accept_ev(accept_ev), .l1_take_ev(l1_take_ev),
    .l2_take_ev(l2_take_ev), .done(rsp_valid)
  );

  pw_l1_decode u_l1 (.desc(mem_rdata), .mva(mva_q), .is_table(l1_is_table), .result(l1_res));

  pw_l2_decode u_l2 (.desc(mem_rdata), .mva(mva_q), .domain(desc_domain(l1_q)), .result(l2_res));

  assign mem_addr = sel_l2 ? second_fetch(l1_q, mva_q) : first_fetch(ttb_q, mva_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mva_q <= '0;
      ttb_q <= '0;
      l1_q  <= '0;
      res_q <= '0;
    end else begin
      if (accept_ev) begin
        mva_q <= mva_w;
        ttb_q <= ttb_base[31:32-TTB_W];
      end
      if (l1_take_ev) begin
        l1_q <= mem_rdata;
        if (!l1_is_table) res_q <= l1_res;
      end
      if (l2_take_ev) res_q <= l2_res;
    end
  end

  assign rsp_paddr  = res_q.paddr;
  assign rsp_ap     = res_q.ap;
  assign rsp_domain = res_q.domain;
  assign rsp_fault  = res_q.fault;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [31:0] ttb_base,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_valid,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_ap,
  input logic [3:0]  rsp_domain,
  input logic        rsp_fault,
  input logic        accept_ev,
  input logic        l1_take_ev,
  input logic        l1_is_table
);
  logic        outst, busy, was_table;
  logic [1:0]  rd_cnt;
  logic [17:0] ttb_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= 1'b0; busy <= 1'b0; was_table <= 1'b0; rd_cnt <= '0; ttb_cap <= '0;
    end else begin
      if (mem_req) outst <= 1'b1;
      else if (mem_valid) outst <= 1'b0;
      if (accept_ev) begin
        busy <= 1'b1; rd_cnt <= '0; was_table <= 1'b0; ttb_cap <= ttb_base[31:14];
      end else begin
        if (rsp_valid) busy <= 1'b0;
        if (mem_req) rd_cnt <= rd_cnt + 2'd1;
        if (l1_take_ev) was_table <= l1_is_table;
      end
    end
  end

  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r12_not_ready_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst);
  a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> !busy);
  a_r3_first_read_base: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rd_cnt == 2'd0) |-> (mem_addr[31:14] == ttb_cap && mem_addr[1:0] == 2'b00));
  a_r4_leaf_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_take_ev && !l1_is_table) |=> rsp_valid);
  a_r5_table_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_take_ev && l1_is_table) |=> mem_req);
  a_r4_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_cnt == (was_table ? 2'd2 : 2'd1)));
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0 && rsp_ap == 2'd0));
  a_r10_l1_fault_no_domain: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !was_table) |-> (rsp_domain == 4'd0));
endmodule

bind page_walker pw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ttb_base(ttb_base),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ap(rsp_ap),
  .rsp_domain(rsp_domain), .rsp_fault(rsp_fault), .accept_ev(accept_ev),
  .l1_take_ev(l1_take_ev), .l1_is_table(l1_is_table)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [6:0]  req_pid = '0;
  logic [31:0] ttb_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_ap;
  logic [3:0]  rsp_domain;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  page_walker u_dut (.*);

  // memory model: fixed latency, small associative store
  logic [31:0] mem_a [16];
  logic [31:0] mem_d [16];
  int          mem_n = 0;
  logic [31:0] rd_log [64];
  int          nreads = 0;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) return mem_d[i];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= lookup(pend_addr);
        pend      <= 1'b0;
      end else lat <= lat - 1;
    end
    if (mem_req) begin
      pend      <= 1'b1;
      lat       <= 2;
      pend_addr <= mem_addr;
      rd_log[nreads % 64] <= mem_addr;
      nreads    <= nreads + 1;
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    mem_a[mem_n] = a; mem_d[mem_n] = d; mem_n++;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side reference arithmetic
  function automatic logic [31:0] ref_mva(input logic [31:0] va, input logic [6:0] pid);
    return (va < 32'h0200_0000) ? va + 32'(pid) * 32'h0200_0000 : va;
  endfunction
  function automatic logic [31:0] ref_l1(input logic [31:0] ttb, input logic [31:0] mva);
    return (ttb & 32'hFFFF_C000) + (mva >> 20) * 4;
  endfunction

  logic [31:0] g_pa, g_a0, g_a1;
  logic [1:0]  g_ap;
  logic [3:0]  g_dom;
  logic        g_flt, g_ready_mid, g_rsp_after;
  int          g_nrd;

  task automatic walk(input logic [31:0] va, input logic [6:0] pid,
                      input logic [31:0] ttb, input bit busy);
    int n0;
    n0 = nreads;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_pid = pid; ttb_base = ttb;
    @(negedge clk);
    g_ready_mid = req_ready;
    if (busy) req_vaddr = va ^ 32'hFFFF_0000;
    else req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    g_pa = rsp_paddr; g_ap = rsp_ap; g_dom = rsp_domain; g_flt = rsp_fault;
    g_nrd = nreads - n0;
    g_a0 = rd_log[n0 % 64]; g_a1 = rd_log[(n0 + 1) % 64];
    req_valid = 1'b0;
    @(negedge clk);
    g_rsp_after = rsp_valid;
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h8123_4567, ttb = 32'h0040_0000, e, mva;
    mem_n = 0;
    mva = ref_mva(va, 7'd5);
    e = 32'hA5A0_0000 | (32'd2 << 10) | (32'd9 << 5) | 32'd2;
    poke(ref_l1(ttb, mva), e);
    walk(va, 7'd5, ttb, 1'b0);
    chk(mva == va, "R2 high VA unchanged", mva, va);
    chk(g_a0 == ref_l1(ttb, va), "R3 first read addr", g_a0, ref_l1(ttb, va));
    chk(g_nrd == 1, "R4 section single read", 32'(g_nrd), 1);
    chk(g_pa == ((e & 32'hFFF0_0000) | (va & 32'h000F_FFFF)), "R4 section paddr", g_pa, 32'hA5A3_4567);
    chk(g_ap == 2'd2, "R4 section ap", 32'(g_ap), 2);
    chk(g_dom == 4'd9, "R13 section domain", 32'(g_dom), 9);
    chk(g_flt == 1'b0, "R4 no fault", 32'(g_flt), 0);
  endtask

  task automatic t_remap();
    logic [31:0] va = 32'h0012_3456, ttb = 32'h0080_C000, mva;
    mem_n = 0;
    mva = ref_mva(va, 7'd3);
    poke(ref_l1(ttb, mva), 32'h3C10_0000 | (32'd1 << 10) | (32'd4 << 5) | 32'd2);
    walk(va, 7'd3, ttb, 1'b0);
    chk(g_a0 == ref_l1(ttb, 32'h0612_3456), "R2 remapped first read", g_a0, ref_l1(ttb, 32'h0612_3456));
    chk(g_pa == 32'h3C12_3456, "R2 remapped paddr", g_pa, 32'h3C12_3456);
  endtask

  task automatic t_coarse_large();
    logic [31:0] ttb = 32'h0040_0000, tbl = 32'h0010_0400, l2e, va, ea;
    for (int q = 0; q < 4; q++) begin
      mem_n = 0;
      va = 32'h4560_0000 | (32'(q) << 14) | 32'h0123;
      poke(ref_l1(ttb, va), tbl | (32'd3 << 5) | 32'd1);
      ea = tbl + ((va >> 12) & 32'hFF) * 4;
      l2e = 32'h7700_0000 | (32'hE4 << 4) | 32'd1;
      poke(ea, l2e);
      walk(va, 7'd0, ttb, 1'b0);
      chk(g_nrd == 2, "R5 two reads", 32'(g_nrd), 2);
      chk(g_a1 == ea, "R5 coarse second addr", g_a1, ea);
      chk(g_pa == ((l2e & 32'hFFFF_0000) + (va & 32'hFFFF)), "R7 large paddr", g_pa, (l2e & 32'hFFFF_0000) + (va & 32'hFFFF));
      chk(g_ap == 2'(q), "R7 large quarter ap", 32'(g_ap), 32'(q));
      chk(g_dom == 4'd3, "R13 large domain", 32'(g_dom), 3);
    end
  endtask

  task automatic t_fine_small();
    logic [31:0] ttb = 32'h0040_0000, tbl = 32'h0020_3000, l2e, va, ea;
    for (int q = 0; q < 4; q++) begin
      mem_n = 0;
      va = 32'h1234_5000 | (32'(q) << 10) | 32'h00AB;
      poke(ref_l1(ttb, va), tbl | (32'd12 << 5) | 32'd3);
      ea = tbl + ((va >> 10) & 32'h3FF) * 4;
      l2e = 32'h9ABC_D000 | (32'h1B << 4) | 32'd2;
      poke(ea, l2e);
      walk(va, 7'd0, ttb, 1'b0);
      chk(g_a1 == ea, "R6 fine second addr", g_a1, ea);
      chk(g_pa == (32'h9ABC_D000 + (va & 32'hFFF)), "R8 small paddr", g_pa, 32'h9ABC_D000 + (va & 32'hFFF));
      chk(g_ap == 2'(3 - q), "R8 small quarter ap", 32'(g_ap), 32'(3 - q));
      chk(g_dom == 4'd12, "R13 small domain", 32'(g_dom), 12);
    end
  endtask

  task automatic t_tiny();
    logic [31:0] ttb = 32'h0040_0000, tbl = 32'h0030_0000, va = 32'h0001_2345, mva, ea;
    mem_n = 0;
    mva = ref_mva(va, 7'd9);
    poke(ref_l1(ttb, mva), tbl | (32'd7 << 5) | 32'd3);
    ea = tbl + ((mva >> 10) & 32'h3FF) * 4;
    poke(ea, 32'h5555_5400 | (32'd2 << 4) | 32'd3);
    walk(va, 7'd9, ttb, 1'b0);
    chk(g_a1 == ea, "R6 fine addr for tiny", g_a1, ea);
    chk(g_pa == 32'h5555_5745, "R9 tiny paddr", g_pa, 32'h5555_5745);
    chk(g_ap == 2'd2, "R9 tiny ap", 32'(g_ap), 2);
  endtask

  task automatic t_l1_fault();
    logic [31:0] ttb = 32'h0040_0000, va = 32'hC000_1000;
    mem_n = 0;
    poke(ref_l1(ttb, va), 32'h1234_5DE0);
    walk(va, 7'd0, ttb, 1'b0);
    chk(g_flt == 1'b1, "R10 fault flag", 32'(g_flt), 1);
    chk(g_nrd == 1, "R10 one read", 32'(g_nrd), 1);
    chk(g_pa == 32'd0 && g_ap == 2'd0 && g_dom == 4'd0, "R10 zero fields",
        {g_pa[23:0], g_dom, 2'b0, g_ap}, 0);
  endtask

  task automatic t_l2_fault();
    logic [31:0] ttb = 32'h0040_0000, va = 32'hD000_2000;
    mem_n = 0;
    poke(ref_l1(ttb, va), 32'h0050_0000 | (32'd5 << 5) | 32'd1);
    walk(va, 7'd0, ttb, 1'b0);
    chk(g_flt == 1'b1, "R11 fault flag", 32'(g_flt), 1);
    chk(g_nrd == 2, "R11 two reads", 32'(g_nrd), 2);
    chk(g_pa == 32'd0 && g_ap == 2'd0, "R11 zero paddr/ap", g_pa, 0);
    chk(g_dom == 4'd5, "R11 domain kept", 32'(g_dom), 5);
  endtask

  task automatic t_busy();
    logic [31:0] ttb = 32'h0040_0000, va = 32'h8800_0042;
    int n1;
    mem_n = 0;
    poke(ref_l1(ttb, va), 32'hBEE0_0000 | (32'd1 << 5) | 32'd2);
    walk(va, 7'd0, ttb, 1'b1);
    chk(g_ready_mid == 1'b0, "R12 not ready during walk", 32'(g_ready_mid), 0);
    chk(g_pa == 32'hBEE0_0042, "R12 held request ignored", g_pa, 32'hBEE0_0042);
    chk(g_rsp_after == 1'b0, "R12 rsp one cycle", 32'(g_rsp_after), 0);
    n1 = nreads;
    repeat (6) @(negedge clk);
    chk(nreads == n1, "R12 no extra walk", 32'(nreads), 32'(n1));
    chk(req_ready == 1'b1, "R12 idle again", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_section();
    t_remap();
    t_coarse_large();
    t_fine_small();
    t_tiny();
    t_l1_fault();
    t_l2_fault();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule